// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block carries out the architectural state update a processor performs when it takes a trap, and the reverse update when a handler returns. On a trap request with a 9-bit trap type, it raises the trap level by one. It saves the current condition codes, address-space identifier, processor-state word, window pointer, PC and next-PC into a stack entry that belongs to the new level. It records the trap type and produces the handler's processor-state word, window pointer, PC and next-PC. These come out together as one registered update for the core to apply.

A built-in alignment checker looks at each memory access the core reports. It raises a trap of its own when an access is not naturally aligned. A trap-return request pops the frame of the current level back onto the update outputs and lowers the level. A trap that arrives when the stack is already full does not push a frame; it puts the block into a sticky error mode instead. The trap base address is held in a local register whose low 15 bits are always zero.

Top module: `trap_seq`

## Requirements
- R1: A trap that is accepted raises `tl_q` by exactly one. From the cycle after the trap, `tt_q` shows the trap type stored for the new level. `tt_q` reads 0 while `tl_q` is 0.
- R2: A trap return while `tl_q` > 0 puts on the update outputs the PC, next-PC, condition codes, ASI, processor state and window pointer saved by the trap that entered the current level, and lowers `tl_q` by one. A return while `tl_q` = 0 is ignored. A trap and a return in the same cycle act as the trap alone.
- R3: The processor-state word uses these bit positions: 0 alternate globals, 1 interrupt enable, 2 privileged, 3 address mask, 4 FPU enable, 5 RED, 7:6 memory model, 8 trap little-endian, 9 current little-endian. On entry, bits 7:6 and 8 are kept. Bit 9 takes the old bit 8. Bits 0 and 2 are set. Bits 1, 3 and 5 are cleared. Bit 4 equals the `HAS_FPU` parameter.
- R4: On entry with trap type 0x024, the new window pointer is the current one plus 1, modulo `NWIN`.
- R5: On entry with a type in 0x080–0x0BF, the new window pointer is current + `cur_cansave` + 2, modulo `NWIN`. With a type in 0x0C0–0x0FF, it is current − 1, modulo `NWIN`. Every other type passes the window pointer through unchanged.
- R6: On entry, `upd_pc` = {`tba_q`[63:15], (level before the trap ≠ 0), trap type, 5'b00000}, and `upd_npc` = `upd_pc` + 4. On entry, `upd_ccr` and `upd_asi` pass the current values through.
- R7: When `acc_valid` is high, the access is misaligned if the low address bits under the size mask are not all zero. The size encodings are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, and 4 to 7 = 16 bytes. A misaligned access raises trap type 0x034. When `trap_req` is high in the same cycle, the type on `trap_type` wins. An aligned access causes no update.
- R8: A trap request while `tl_q` = `MAX_TL` sets `error_mode`, pushes nothing, raises no update and leaves `tl_q` unchanged. Once `error_mode` is set, it stays set until reset, and all trap and return requests are ignored.
- R9: A write to the base register stores `tba_wdata` with bits 14:0 forced to zero. `tba_q` bits 14:0 always read zero.
- R10: Each update is registered. `upd_valid` is high for the one cycle after the request edge; `upd_kind` is 0 for an entry and 1 for a return. After reset, `tl_q`, `tt_q`, `tba_q`, `upd_valid` and `error_mode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request |
| trap_type | input | 9 | Trap type of the request |
| ret_req | input | 1 | Trap-return request |
| acc_valid | input | 1 | A memory access is being reported |
| acc_size | input | 3 | Access size code (R7) |
| acc_addr_lo | input | 4 | Low four address bits of the access |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next-PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 10 | Current processor-state word (R3 layout) |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Count of windows available to save |
| tba_we | input | 1 | Base register write enable |
| tba_wdata | input | 64 | Base register write data |
| tba_q | output | 64 | Base register value |
| tl_q | output | TL_W | Current trap level |
| tt_q | output | 9 | Trap type stored for the current level |
| upd_valid | output | 1 | Update outputs are valid this cycle |
| upd_kind | output | 1 | 0 for an entry, 1 for a return |
| upd_pc | output | 64 | PC to load |
| upd_npc | output | 64 | Next-PC to load |
| upd_ccr | output | 8 | Condition codes to load |
| upd_asi | output | 8 | ASI to load |
| upd_pstate | output | 10 | Processor-state word to load |
| upd_cwp | output | CWP_W | Window pointer to load |
| error_mode | output | 1 | Sticky error mode, set when the trap stack overflows |

## Verification
The hardest case to reach is a return from a deep level. Getting there needs a sequence of nested traps, each with different saved state, followed by pops that must bring back exactly the frame of the matching level. Getting this wrong shows up only several operations later. The stimulus is a seeded random walk of traps, returns, checker-raised traps and base writes, with all current-state inputs randomised on every operation. A bench model of the stack checks every pop. Directed steps then cover the window trap ranges with wrap-around, the trap/return collision, a return at level zero, and the climb to the maximum level that ends in error mode.

// File: rtl/trapseq_pkg.sv
// Package: shared frame type, processor-state bit positions and the
// vector-address and trap-state helper functions of the trap sequencer.
package trapseq_pkg;
    localparam int PS_W      = 10;
    localparam int PS_AG     = 0;
    localparam int PS_IE     = 1;
    localparam int PS_PRIV   = 2;
    localparam int PS_AM     = 3;
    localparam int PS_PEF    = 4;
    localparam int PS_RED    = 5;
    localparam int PS_MM_LO  = 6;
    localparam int PS_TLE    = 8;
    localparam int PS_CLE    = 9;
    localparam int CWP_MAX_W = 5;
    localparam logic [8:0] TT_MISALIGN = 9'h034;

    typedef struct packed {
        logic [63:0]          pc;
        logic [63:0]          npc;
        logic [7:0]           ccr;
        logic [7:0]           asi;
        logic [PS_W-1:0]      ps;
        logic [CWP_MAX_W-1:0] cwp;
        logic [8:0]           tt;
    } tframe_t;

    // Processor-state word that a handler starts with.
    function automatic logic [PS_W-1:0] trap_pstate(input logic [PS_W-1:0] old,
                                                    input logic fpu);
        logic [PS_W-1:0] ps;
        ps                     = '0;
        ps[PS_MM_LO+1:PS_MM_LO] = old[PS_MM_LO+1:PS_MM_LO];
        ps[PS_TLE]             = old[PS_TLE];
        ps[PS_CLE]             = old[PS_TLE];
        ps[PS_PEF]             = fpu;
        ps[PS_PRIV]            = 1'b1;
        ps[PS_AG]              = 1'b1;
        return ps;
    endfunction

    // Handler entry address from the base, the nesting bit and the type.
    function automatic logic [63:0] vec_addr(input logic [48:0] base_hi,
                                             input logic nested,
                                             input logic [8:0] tt);
        return {base_hi, nested, tt, 5'b00000};
    endfunction
endpackage

// File: rtl/align_chk.sv
// Alignment checker: flags an access whose low address bits are not zero
// under the natural-alignment mask of its size. Assumes size codes
// 0..3 = 1..8 bytes and any larger code = 16 bytes.
module align_chk (
    input  logic       acc_valid,
    input  logic [2:0] acc_size,
    input  logic [3:0] acc_addr_lo,
    output logic       misal
);
    logic [3:0] mask;

    // Select the mask of address bits that must be zero for this size.
    always_comb begin
        case (acc_size)
            3'd0:    mask = 4'b0000;
            3'd1:    mask = 4'b0001;
            3'd2:    mask = 4'b0011;
            3'd3:    mask = 4'b0111;
            default: mask = 4'b1111;
        endcase
        misal = acc_valid && (|(acc_addr_lo & mask));
    end
endmodule

// File: rtl/cwp_adj.sv
// Window pointer adjust: produces the handler's window pointer from the
// trap type range. Assumes the window count is a power of two, so all
// sums wrap modulo the window count by width truncation.
module cwp_adj #(
    parameter int CWP_W = 3
) (
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    input  logic [8:0]       tt,
    output logic [CWP_W-1:0] cwp_nxt
);
    // Pick the adjustment for clean, spill and fill types.
    always_comb begin
        if (tt == 9'h024)
            cwp_nxt = cwp + CWP_W'(1);
        else if (tt[8:6] == 3'b010)
            cwp_nxt = cwp + cansave + CWP_W'(2);
        else if (tt[8:6] == 3'b011)
            cwp_nxt = cwp - CWP_W'(1);
        else
            cwp_nxt = cwp;
    end
endmodule

// File: rtl/trap_stack.sv
// Per-level trap frame storage: one frame register per level 1..MAX_TL,
// written on a push, read combinationally by level. Level 0 reads zero.
module trap_stack
    import trapseq_pkg::*;
#(
    parameter int MAX_TL = 4,
    parameter int TL_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [TL_W-1:0] push_lvl,
    input  tframe_t         push_data,
    input  logic [TL_W-1:0] rd_lvl,
    output tframe_t         rd_data
);
    tframe_t frames [MAX_TL:1];

    for (genvar g = 1; g <= MAX_TL; g++) begin : g_lvl
        // Hold the frame pushed for level g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                frames[g] <= '0;
            else if (push_en && push_lvl == TL_W'(g))
                frames[g] <= push_data;
        end
    end

    // Read the frame of the requested level.
    always_comb begin
        rd_data = '0;
        for (int i = 1; i <= MAX_TL; i++)
            if (rd_lvl == TL_W'(i))
                rd_data = frames[i];
    end
endmodule

// File: rtl/trap_seq.sv
// Trap entry sequencer top: accepts traps (external or from the alignment
// checker) and returns, keeps the trap level and base register, pushes and
// pops frames, and presents one registered state update per event.
// Assumes NWIN is a power of two between 2 and 32 and MAX_TL >= 1.
module trap_seq
    import trapseq_pkg::*;
#(
    parameter int MAX_TL  = 4,
    parameter int NWIN    = 8,
    parameter bit HAS_FPU = 1'b1,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int TL_W   = $clog2(MAX_TL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [8:0]       trap_type,
    input  logic             ret_req,
    input  logic             acc_valid,
    input  logic [2:0]       acc_size,
    input  logic [3:0]       acc_addr_lo,
    input  logic [63:0]      cur_pc,
    input  logic [63:0]      cur_npc,
    input  logic [7:0]       cur_ccr,
    input  logic [7:0]       cur_asi,
    input  logic [PS_W-1:0]  cur_pstate,
    input  logic [CWP_W-1:0] cur_cwp,
    input  logic [CWP_W-1:0] cur_cansave,
    input  logic             tba_we,
    input  logic [63:0]      tba_wdata,
    output logic [63:0]      tba_q,
    output logic [TL_W-1:0]  tl_q,
    output logic [8:0]       tt_q,
    output logic             upd_valid,
    output logic             upd_kind,
    output logic [63:0]      upd_pc,
    output logic [63:0]      upd_npc,
    output logic [7:0]       upd_ccr,
    output logic [7:0]       upd_asi,
    output logic [PS_W-1:0]  upd_pstate,
    output logic [CWP_W-1:0] upd_cwp,
    output logic             error_mode
);
    logic             misal;
    logic             any_trap;
    logic             take_trap;
    logic             overflow;
    logic             take_ret;
    logic [8:0]       eff_tt;
    logic [CWP_W-1:0] cwp_new;
    logic [63:0]      vec;
    tframe_t          push_frame;
    tframe_t          top_frame;

    align_chk u_align (
        .acc_valid  (acc_valid),
        .acc_size   (acc_size),
        .acc_addr_lo(acc_addr_lo),
        .misal      (misal)
    );

    cwp_adj #(.CWP_W(CWP_W)) u_cwp (
        .cwp    (cur_cwp),
        .cansave(cur_cansave),
        .tt     (eff_tt),
        .cwp_nxt(cwp_new)
    );

    trap_stack #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (take_trap),
        .push_lvl (tl_q + TL_W'(1)),
        .push_data(push_frame),
        .rd_lvl   (tl_q),
        .rd_data  (top_frame)
    );

    // Decide which event, if any, is taken this cycle and build the frame.
    always_comb begin
        any_trap  = trap_req || misal;
        eff_tt    = trap_req ? trap_type : TT_MISALIGN;
        take_trap = !error_mode && any_trap && (tl_q != TL_W'(MAX_TL));
        overflow  = !error_mode && any_trap && (tl_q == TL_W'(MAX_TL));
        take_ret  = !error_mode && !any_trap && ret_req && (tl_q != '0);
        vec       = vec_addr(tba_q[63:15], tl_q != '0, eff_tt);
        push_frame.pc  = cur_pc;
        push_frame.npc = cur_npc;
        push_frame.ccr = cur_ccr;
        push_frame.asi = cur_asi;
        push_frame.ps  = cur_pstate;
        push_frame.cwp = CWP_MAX_W'(cur_cwp);
        push_frame.tt  = eff_tt;
    end

    assign tt_q = top_frame.tt;

    // Trap level, error mode and base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q       <= '0;
            error_mode <= 1'b0;
            tba_q      <= '0;
        end else begin
            if (take_trap)
                tl_q <= tl_q + TL_W'(1);
            else if (take_ret)
                tl_q <= tl_q - TL_W'(1);
            if (overflow)
                error_mode <= 1'b1;
            if (tba_we)
                tba_q <= tba_wdata & ~64'h7FFF;
        end
    end

    // Registered state update presented to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid  <= 1'b0;
            upd_kind   <= 1'b0;
            upd_pc     <= '0;
            upd_npc    <= '0;
            upd_ccr    <= '0;
            upd_asi    <= '0;
            upd_pstate <= '0;
            upd_cwp    <= '0;
        end else begin
            upd_valid <= take_trap || take_ret;
            if (take_trap) begin
                upd_kind   <= 1'b0;
                upd_pc     <= vec;
                upd_npc    <= vec + 64'd4;
                upd_ccr    <= cur_ccr;
                upd_asi    <= cur_asi;
                upd_pstate <= trap_pstate(cur_pstate, HAS_FPU);
                upd_cwp    <= cwp_new;
            end else if (take_ret) begin
                upd_kind   <= 1'b1;
                upd_pc     <= top_frame.pc;
                upd_npc    <= top_frame.npc;
                upd_ccr    <= top_frame.ccr;
                upd_asi    <= top_frame.asi;
                upd_pstate <= top_frame.ps;
                upd_cwp    <= CWP_W'(top_frame.cwp);
            end
        end
    end

    AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_kind |-> tl_q == TL_W'($past(tl_q) + TL_W'(1))); // R1
    AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_kind |-> tl_q == TL_W'($past(tl_q) - TL_W'(1))); // R2
    AST_ENTRY_PSTATE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_kind |-> upd_pstate[PS_PRIV] && !upd_pstate[PS_IE]
            && upd_pstate[PS_AG] && !upd_pstate[PS_RED] && !upd_pstate[PS_AM]); // R3
    AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_kind |-> upd_npc == upd_pc + 64'd4); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        error_mode |=> error_mode); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        error_mode |-> !upd_valid && $stable(tl_q)); // R8
    AST_TBA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tba_q[14:0] == 15'd0); // R9
endmodule

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/1ps
module trap_seq_tb_top;
    localparam int MAX_TL = 4;
    localparam int NWIN   = 8;
    localparam int CW     = 3;
    localparam int TW     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 0, ret_req = 0, acc_valid = 0, tba_we = 0;
    logic [8:0] trap_type = '0;
    logic [2:0] acc_size = '0;
    logic [3:0] acc_addr_lo = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0, tba_wdata = '0;
    logic [7:0] cur_ccr = '0, cur_asi = '0;
    logic [9:0] cur_pstate = '0;
    logic [CW-1:0] cur_cwp = '0, cur_cansave = '0;
    logic [63:0] tba_q, upd_pc, upd_npc;
    logic [TW-1:0] tl_q;
    logic [8:0] tt_q;
    logic upd_valid, upd_kind, error_mode;
    logic [7:0] upd_ccr, upd_asi;
    logic [9:0] upd_pstate;
    logic [CW-1:0] upd_cwp;

    int checks = 0;
    int failures = 0;

    // Bench model
    int m_tl = 0;
    logic [63:0] m_tba = '0;
    logic [63:0] s_pc [1:MAX_TL];
    logic [63:0] s_npc [1:MAX_TL];
    logic [7:0]  s_ccr [1:MAX_TL];
    logic [7:0]  s_asi [1:MAX_TL];
    logic [9:0]  s_ps  [1:MAX_TL];
    logic [CW-1:0] s_cwp [1:MAX_TL];
    logic [8:0]  s_tt  [1:MAX_TL];

    trap_seq #(.MAX_TL(MAX_TL), .NWIN(NWIN), .HAS_FPU(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .ret_req(ret_req), .acc_valid(acc_valid), .acc_size(acc_size),
        .acc_addr_lo(acc_addr_lo), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
        .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .tba_we(tba_we),
        .tba_wdata(tba_wdata), .tba_q(tba_q), .tl_q(tl_q), .tt_q(tt_q),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_pc(upd_pc),
        .upd_npc(upd_npc), .upd_ccr(upd_ccr), .upd_asi(upd_asi),
        .upd_pstate(upd_pstate), .upd_cwp(upd_cwp), .error_mode(error_mode)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_ps(input logic [9:0] o);
        logic [9:0] p = 10'd0;
        p[7:6] = o[7:6]; p[8] = o[8]; p[9] = o[8];
        p[4] = 1'b1; p[2] = 1'b1; p[0] = 1'b1;
        return p;
    endfunction

    function automatic logic [CW-1:0] exp_cwp(input logic [8:0] t, input int c, input int cs);
        if (t == 9'h024) return CW'((c + 1) % NWIN);
        if (t >= 9'h080 && t <= 9'h0BF) return CW'((c + cs + 2) % NWIN);
        if (t >= 9'h0C0 && t <= 9'h0FF) return CW'((c + NWIN - 1) % NWIN);
        return CW'(c);
    endfunction

    function automatic logic exp_mis(input logic v, input logic [2:0] sz, input logic [3:0] lo);
        logic [3:0] m;
        m = (sz == 0) ? 4'h0 : (sz == 1) ? 4'h1 : (sz == 2) ? 4'h3 : (sz == 3) ? 4'h7 : 4'hF;
        return v && ((lo & m) != 0);
    endfunction

    // Apply one operation, check the registered result, update the model.
    task automatic op(input logic trq, input logic [8:0] tt, input logic rrq,
                      input logic av, input logic [2:0] asz, input logic [3:0] alo,
                      input logic twe, input logic [63:0] twd);
        logic mis, trap, ret, ovf;
        logic [8:0] ett;
        logic [63:0] epc;
        @(negedge clk);
        trap_req = trq; trap_type = tt; ret_req = rrq; acc_valid = av;
        acc_size = asz; acc_addr_lo = alo; tba_we = twe; tba_wdata = twd;
        cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
        cur_ccr = 8'($urandom); cur_asi = 8'($urandom);
        cur_pstate = 10'($urandom); cur_cwp = CW'($urandom); cur_cansave = CW'($urandom);
        mis = exp_mis(av, asz, alo);
        ett = trq ? tt : 9'h034;
        trap = (trq || mis) && !error_mode && m_tl < MAX_TL;
        ovf = (trq || mis) && !error_mode && m_tl == MAX_TL;
        ret = !(trq || mis) && rrq && !error_mode && m_tl > 0;
        @(posedge clk); #1;
        trap_req = 0; ret_req = 0; acc_valid = 0; tba_we = 0;
        chk("R10 upd_valid", upd_valid, trap || ret);
        if (trap) begin
            epc = {m_tba[63:15], m_tl != 0, ett, 5'b0};
            chk("R1 upd_kind entry", upd_kind, 0);
            chk("R6 upd_pc", upd_pc, epc);
            chk("R6 upd_npc", upd_npc, epc + 4);
            chk("R6 upd_ccr", upd_ccr, cur_ccr);
            chk("R6 upd_asi", upd_asi, cur_asi);
            chk("R3 upd_pstate", upd_pstate, exp_ps(cur_pstate));
            chk("R5 upd_cwp", upd_cwp, exp_cwp(ett, cur_cwp, cur_cansave));
            if (mis && !trq) chk("R7 misalign type", tt_q, 9'h034);
            m_tl++;
            s_pc[m_tl] = cur_pc; s_npc[m_tl] = cur_npc; s_ccr[m_tl] = cur_ccr;
            s_asi[m_tl] = cur_asi; s_ps[m_tl] = cur_pstate; s_cwp[m_tl] = cur_cwp;
            s_tt[m_tl] = ett;
        end else if (ret) begin
            chk("R2 upd_kind return", upd_kind, 1);
            chk("R2 upd_pc", upd_pc, s_pc[m_tl]);
            chk("R2 upd_npc", upd_npc, s_npc[m_tl]);
            chk("R2 upd_ccr", upd_ccr, s_ccr[m_tl]);
            chk("R2 upd_asi", upd_asi, s_asi[m_tl]);
            chk("R2 upd_pstate", upd_pstate, s_ps[m_tl]);
            chk("R2 upd_cwp", upd_cwp, s_cwp[m_tl]);
            m_tl--;
        end
        if (ovf) chk("R8 error_mode set", error_mode, 1);
        if (twe) m_tba = twd & ~64'h7FFF;
        chk("R1 tl_q", tl_q, m_tl);
        chk("R1 tt_q", tt_q, (m_tl == 0) ? 9'd0 : s_tt[m_tl]);
        chk("R9 tba_q", tba_q, m_tba);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R10 reset tl_q", tl_q, 0);
        chk("R10 reset tt_q", tt_q, 0);
        chk("R10 reset tba_q", tba_q, 0);
        chk("R10 reset upd_valid", upd_valid, 0);
        chk("R10 reset error_mode", error_mode, 0);
        // R2: return at level zero is ignored
        op(0, 0, 1, 0, 0, 0, 0, 0);
        // R9: all-ones base write reads low bits as zero
        op(0, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        // R4, R5: window type ranges including range edges
        op(1, 9'h024, 0, 0, 0, 0, 0, 0);
        op(1, 9'h080, 0, 0, 0, 0, 0, 0);
        op(1, 9'h0BF, 0, 0, 0, 0, 0, 0);
        op(1, 9'h0C0, 0, 0, 0, 0, 0, 0);
        op(0, 0, 1, 0, 0, 0, 0, 0);
        op(0, 0, 1, 0, 0, 0, 0, 0);
        op(1, 9'h0FF, 1, 0, 0, 0, 0, 0);   // R2: trap and return together -> trap only
        op(1, 9'h100, 0, 0, 0, 0, 0, 0);   // R5: type outside window ranges
        // R7: misaligned access with and without a concurrent trap
        op(0, 0, 1, 0, 0, 0, 0, 0);
        op(0, 0, 1, 0, 0, 0, 0, 0);
        op(0, 0, 0, 1, 3'd2, 4'h2, 0, 0);
        op(1, 9'h041, 0, 1, 3'd1, 4'h1, 0, 0);
        op(0, 0, 0, 1, 3'd3, 4'h8, 0, 0);  // aligned: no update
        op(0, 0, 1, 0, 0, 0, 0, 0);
        op(0, 0, 1, 0, 0, 0, 0, 0);
        // Random walk
        for (int n = 0; n < 1500; n++) begin
            int sel = $urandom_range(0, 99);
            logic [8:0] t;
            case ($urandom_range(0, 3))
                0: t = 9'h024;
                1: t = 9'h080 + 9'($urandom_range(0, 63));
                2: t = 9'h0C0 + 9'($urandom_range(0, 63));
                default: t = 9'($urandom);
            endcase
            if (sel < 45 && m_tl < MAX_TL)
                op(1, t, 0, 0, 0, 0, 0, 0);
            else if (sel < 55 && m_tl < MAX_TL)
                op(0, 0, 0, 1, 3'($urandom), 4'($urandom), 0, 0);
            else if (sel < 92)
                op(0, 0, 1, 0, 0, 0, 0, 0);
            else
                op(0, 0, 0, 0, 0, 0, 1, {$urandom, $urandom});
        end
        // R8: climb to the top and overflow
        while (m_tl < MAX_TL) op(1, 9'h060, 0, 0, 0, 0, 0, 0);
        op(1, 9'h061, 0, 0, 0, 0, 0, 0);
        chk("R8 error_mode after overflow", error_mode, 1);
        op(0, 0, 1, 0, 0, 0, 0, 0);
        chk("R8 return ignored in error mode tl_q", tl_q, MAX_TL);
        chk("R8 error_mode sticky", error_mode, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule